// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that completes one instruction per clock cycle. It supports a small load/store instruction subset:

- load word and store word;
- register-to-register add, subtract, AND, OR and signed set-less-than;
- branch-if-equal;
- an unconditional jump.

Fetch, register read, ALU work, memory access and write-back all take place inside one cycle. The program counter, the register file and the data memory update together on the rising clock edge.

Control is split into two levels. A main decoder looks at the opcode and produces the datapath selects and a 2-bit ALU mode. A second decoder combines that mode with the function field to pick the ALU operation.

Instruction and data memories are internal word arrays. They are filled through a load port while the core is held in reset. The outputs expose the current PC, the register write-back of the current instruction, and any data-memory store. A surrounding bench or system can observe execution at these outputs without reaching inside the block.

Top module: `sc_cpu`

## Requirements
- R1: While rst_n is low the PC reads 0 and no register write (wb_en) or memory store (st_en) is reported. The load port (prog_we with prog_dmem selecting data memory when 1, else instruction memory) writes word prog_addr[31:2].
- R2: Opcode 0x00 with function field instr[5:0] of 0x20/0x22/0x24/0x25/0x2A writes rs+rt, rs-rt, rs&rt, rs|rt or (signed rs < signed rt ? 1 : 0) into rd (instr[15:11]). Here rs is instr[25:21] and rt is instr[20:16].
- R3: Opcode 0x23 (load word) writes into rt the data word at index (rs + sign-extended instr[15:0]) bits 31–2.
- R4: Opcode 0x2B (store word) stores the rt register at address rs + sign-extended instr[15:0] and writes no register.
- R5: Opcode 0x04 (branch-if-equal) sets the next PC to PC+4+(sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. It writes nothing.
- R6: Opcode 0x02 (jump) sets the next PC to {PC+4 bits 31–28, instr[25:0], 2'b00}.
- R7: Register 0 always reads as zero. A write aimed at it is dropped and wb_en stays low.
- R8: Exactly one instruction executes per clock. Every instruction other than a taken branch or a jump advances the PC by 4.
- R9: Any other opcode writes no register, stores nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Load-port write strobe |
| prog_dmem | input | 1 | Load-port target: 1 data memory, 0 instruction memory |
| prog_addr | input | 32 | Load-port byte address |
| prog_data | input | 32 | Load-port write word |
| pc | output | 32 | Address of the instruction executing this cycle |
| wb_en | output | 1 | A register is written at the next edge |
| wb_reg | output | 5 | Destination register number |
| wb_data | output | 32 | Value written to the register |
| st_en | output | 1 | A data-memory store happens at the next edge |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |

## Verification
The bench builds the core with a 32-word instruction memory and a 16-word data memory.

These small arrays keep the program short. With them, one run covers:

- every R-type function, including a signed compare of a negative operand;
- a dropped write to register 0;
- a store followed by a load of the same word;
- a forward branch that is taken and one that is not;
- an unknown opcode;
- a jump;
- a backward branch with a negative offset, which closes a loop that keeps running until the scoreboard drains.

// File: rtl/sc_cpu.sv
module sc_cpu #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_we,
  input  logic        prog_dmem,
  input  logic [31:0] prog_addr,
  input  logic [31:0] prog_data,
  output logic [31:0] pc,
  output logic        wb_en,
  output logic [4:0]  wb_reg,
  output logic [31:0] wb_data,
  output logic        st_en,
  output logic [31:0] st_addr,
  output logic [31:0] st_data
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [1:0] MODE_ADD  = 2'b00;
  localparam logic [1:0] MODE_SUB  = 2'b01;
  localparam logic [1:0] MODE_FUNC = 2'b10;

  localparam logic [2:0] ALU_ADD = 3'd0;
  localparam logic [2:0] ALU_SUB = 3'd1;
  localparam logic [2:0] ALU_AND = 3'd2;
  localparam logic [2:0] ALU_OR  = 3'd3;
  localparam logic [2:0] ALU_SLT = 3'd4;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  logic [31:0] instr;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  logic [31:0] imm_ext;

  logic        dst_is_rd, b_is_imm, wb_from_mem, reg_write, mem_write;
  logic        is_beq, is_jump;
  logic [1:0]  alu_mode;
  logic [2:0]  alu_op;

  logic [31:0] rs_val, rt_val, alu_b, alu_y, ld_data;
  logic        alu_zero;
  logic [4:0]  dst;
  logic [31:0] pc_plus4, br_target, jmp_target, pc_next;

  assign instr   = imem[pc[IAW+1:2]];
  assign opcode  = instr[31:26];
  assign rs      = instr[25:21];
  assign rt      = instr[20:16];
  assign rd      = instr[15:11];
  assign funct   = instr[5:0];
  assign imm_ext = {{16{instr[15]}}, instr[15:0]};

  always_comb begin
    dst_is_rd   = 1'b0;
    b_is_imm    = 1'b0;
    wb_from_mem = 1'b0;
    reg_write   = 1'b0;
    mem_write   = 1'b0;
    is_beq      = 1'b0;
    is_jump     = 1'b0;
    alu_mode    = MODE_ADD;
    case (opcode)
      OP_RTYPE: begin
        dst_is_rd = 1'b1;
        reg_write = 1'b1;
        alu_mode  = MODE_FUNC;
      end
      OP_LOAD: begin
        b_is_imm    = 1'b1;
        wb_from_mem = 1'b1;
        reg_write   = 1'b1;
      end
      OP_STORE: begin
        b_is_imm  = 1'b1;
        mem_write = 1'b1;
      end
      OP_BEQ: begin
        is_beq   = 1'b1;
        alu_mode = MODE_SUB;
      end
      OP_JUMP: is_jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (alu_mode)
      MODE_SUB:  alu_op = ALU_SUB;
      MODE_FUNC: begin
        case (funct)
          6'h22:   alu_op = ALU_SUB;
          6'h24:   alu_op = ALU_AND;
          6'h25:   alu_op = ALU_OR;
          6'h2A:   alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
      default:   alu_op = ALU_ADD;
    endcase
  end

  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign alu_b  = b_is_imm ? imm_ext : rt_val;

  always_comb begin
    case (alu_op)
      ALU_SUB: alu_y = rs_val - alu_b;
      ALU_AND: alu_y = rs_val & alu_b;
      ALU_OR:  alu_y = rs_val | alu_b;
      ALU_SLT: alu_y = {31'd0, $signed(rs_val) < $signed(alu_b)};
      default: alu_y = rs_val + alu_b;
    endcase
  end
  assign alu_zero = (alu_y == 32'd0);

  assign ld_data = dmem[alu_y[DAW+1:2]];
  assign dst     = dst_is_rd ? rd : rt;

  assign wb_en   = rst_n && reg_write && (dst != 5'd0);
  assign wb_reg  = dst;
  assign wb_data = wb_from_mem ? ld_data : alu_y;
  assign st_en   = rst_n && mem_write;
  assign st_addr = alu_y;
  assign st_data = rt_val;

  assign pc_plus4   = pc + 32'd4;
  assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign pc_next    = is_jump ? jmp_target :
                      (is_beq && alu_zero) ? br_target : pc_plus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= 32'd0;
    else        pc <= pc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (wb_en) begin
      rf[wb_reg] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (prog_we && !prog_dmem) imem[prog_addr[IAW+1:2]] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (st_en)                     dmem[st_addr[DAW+1:2]]   <= st_data;
    else if (prog_we && prog_dmem) dmem[prog_addr[DAW+1:2]] <= prog_data;
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, prog_addr, pc_plus4[1:0], instr[10:6], alu_y};
endmodule

module sc_cpu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic        wb_en,
  input logic [4:0]  wb_reg,
  input logic        st_en,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);
  logic [5:0]  op;
  logic [31:0] sext;
  logic        known;
  assign op    = instr[31:26];
  assign sext  = {{16{instr[15]}}, instr[15:0]};
  assign known = (op == 6'h00) || (op == 6'h23) || (op == 6'h2B) ||
                 (op == 6'h04) || (op == 6'h02);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pc == 32'd0) && !wb_en && !st_en);

  // R4
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !wb_en);

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_reg != 5'd0));

  // R8
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 6'h04 && op != 6'h02) |=> pc == $past(pc) + 32'd4);

  // R5
  beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h04 && rs_val == rt_val) |=>
      pc == $past(pc) + 32'd4 + {$past(sext[29:0]), 2'b00});

  // R5
  beq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h04 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

  // R6
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h02) |=>
      pc == {$past(pc[31:28] + {3'd0, &pc[27:2]}), $past(instr[25:0]), 2'b00});

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> !wb_en && !st_en);
endmodule

bind sc_cpu sc_cpu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .wb_en(wb_en), .wb_reg(wb_reg),
  .st_en(st_en), .instr(instr), .rs_val(rs_val), .rt_val(rt_val)
);

// File: tb/sim_sc_cpu.sv
module sim_sc_cpu;
  localparam int IW = 32;
  localparam int DW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0, prog_dmem = 1'b0;
  logic [31:0] prog_addr = '0, prog_data = '0;
  logic [31:0] pc, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_reg;

  always #4 clk = ~clk;

  sc_cpu #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_dmem(prog_dmem),
    .prog_addr(prog_addr), .prog_data(prog_data), .pc(pc),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data));

  typedef struct {
    logic [31:0] pc;
    logic        wb_en;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;
    logic        st_en;
    logic [31:0] st_addr;
    logic [31:0] st_data;
    string       tag;
  } item_t;

  item_t       exp_q [$];
  item_t       cur;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] prog [IW];
  logic [31:0] dinit [DW];

  function automatic logic [31:0] rtype(int s, int t, int d, logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, int s, int t, logic [15:0] imm);
    return {op, 5'(s), 5'(t), imm};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic build_expect(int ncyc);
    logic [31:0] r [32];
    logic [31:0] d [DW];
    logic [31:0] p = 32'd0;
    for (int i = 0; i < 32; i++) r[i] = 32'd0;
    for (int i = 0; i < DW; i++) d[i] = dinit[i];
    for (int c = 0; c < ncyc; c++) begin
      logic [31:0] ins = prog[(p >> 2) % IW];
      logic [5:0]  op = ins[31:26];
      logic [31:0] a = r[ins[25:21]];
      logic [31:0] b = r[ins[20:16]];
      logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] np = p + 32'd4;
      item_t e;
      e.pc = p; e.wb_en = 1'b0; e.wb_reg = '0; e.wb_data = '0;
      e.st_en = 1'b0; e.st_addr = '0; e.st_data = '0; e.tag = "R9";
      case (op)
        6'h00: begin
          logic [31:0] y;
          case (ins[5:0])
            6'h22:   y = a - b;
            6'h24:   y = a & b;
            6'h25:   y = a | b;
            6'h2A:   y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: y = a + b;
          endcase
          e.wb_reg = ins[15:11]; e.wb_data = y;
          e.wb_en = (ins[15:11] != 5'd0);
          e.tag = e.wb_en ? "R2" : "R7";
          if (e.wb_en) r[ins[15:11]] = y;
        end
        6'h23: begin
          e.wb_reg = ins[20:16]; e.wb_data = d[((a + sx) >> 2) % DW];
          e.wb_en = (ins[20:16] != 5'd0); e.tag = "R3";
          if (e.wb_en) r[ins[20:16]] = e.wb_data;
        end
        6'h2B: begin
          e.st_en = 1'b1; e.st_addr = a + sx; e.st_data = b; e.tag = "R4";
          d[((a + sx) >> 2) % DW] = b;
        end
        6'h04: begin
          e.tag = "R5";
          if (a == b) np = p + 32'd4 + (sx << 2);
        end
        6'h02: begin
          e.tag = "R6";
          np = {np[31:28], ins[25:0], 2'b00};
        end
        default: ;
      endcase
      exp_q.push_back(e);
      p = np;
    end
  endtask

  task automatic load_word(logic sel, int idx, logic [31:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_dmem = sel; prog_addr = 32'(idx * 4); prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
    // R1
    check("R1", "pc in reset", pc, 32'd0);
    check("R1", "wb_en in reset", {31'd0, wb_en}, 32'd0);
    check("R1", "st_en in reset", {31'd0, st_en}, 32'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      // R8
      check("R8", "pc", pc, cur.pc);
      check(cur.tag, "wb_en", {31'd0, wb_en}, {31'd0, cur.wb_en});
      if (cur.wb_en) begin
        check(cur.tag, "wb_reg", {27'd0, wb_reg}, {27'd0, cur.wb_reg});
        check(cur.tag, "wb_data", wb_data, cur.wb_data);
      end
      check(cur.tag, "st_en", {31'd0, st_en}, {31'd0, cur.st_en});
      if (cur.st_en) begin
        check(cur.tag, "st_addr", st_addr, cur.st_addr);
        check(cur.tag, "st_data", st_data, cur.st_data);
      end
    end
  end

  initial begin
    int cyc = 0;
    for (int i = 0; i < IW; i++) prog[i] = 32'd0;
    for (int i = 0; i < DW; i++) dinit[i] = 32'd0;
    dinit[0] = 32'd7;
    dinit[1] = 32'hFFFF_FFFD;
    prog[0]  = itype(6'h23, 0, 1, 16'd0);
    prog[1]  = itype(6'h23, 0, 2, 16'd4);
    prog[2]  = rtype(1, 2, 3, 6'h20);
    prog[3]  = rtype(1, 2, 4, 6'h22);
    prog[4]  = rtype(1, 2, 5, 6'h24);
    prog[5]  = rtype(1, 2, 6, 6'h25);
    prog[6]  = rtype(2, 1, 7, 6'h2A);
    prog[7]  = rtype(1, 2, 8, 6'h2A);
    prog[8]  = rtype(1, 1, 0, 6'h20);
    prog[9]  = rtype(0, 0, 9, 6'h20);
    prog[10] = itype(6'h2B, 0, 3, 16'd8);
    prog[11] = itype(6'h23, 0, 10, 16'd8);
    prog[12] = itype(6'h04, 1, 2, 16'd5);
    prog[13] = itype(6'h04, 3, 10, 16'd2);
    prog[14] = rtype(1, 1, 11, 6'h20);
    prog[15] = rtype(1, 1, 12, 6'h20);
    prog[16] = 32'hFC00_0000;
    prog[17] = itype(6'h2B, 0, 4, 16'd12);
    prog[18] = {6'h02, 26'd20};
    prog[19] = rtype(1, 1, 13, 6'h20);
    prog[20] = itype(6'h04, 0, 0, 16'hFFFD);

    for (int i = 0; i < 21; i++) load_word(1'b0, i, prog[i]);
    load_word(1'b1, 0, dinit[0]);
    load_word(1'b1, 1, dinit[1]);
    build_expect(40);

    @(posedge clk);
    #1 rst_n = 1'b1;
    while (exp_q.size() > 0 && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (exp_q.size() > 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog pending=%0d expected=0", exp_q.size());
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule